// File: doc/BRIEF.md
# Low-Power Interval Timer

This block is a timer that counts in a slow clock domain and is configured over a simple register bus in a fast bus clock domain. A 32-bit counter advances once every 2^(PSEL+1) source pulses of a prescaler. The source is either every edge of the slow clock or every rising edge of an auxiliary tick input. The block raises three event flags: counter wrap, a single compare alarm, and a periodic tap taken from the prescaler. Each flag can drive the bus-side interrupt line through a mask. In the slow domain, each flag can drive a wake line through a separate per-flag wake enable.

Registers that the counter logic uses live in the slow domain. A bus write to one of them is held in a staging register and handed across the clock boundary by a toggle handshake. While that handoff is in flight, a busy flag is shown. Any further write to the same group is dropped. The clock-control register has its own handshake and its own busy flag. Software polls the status register, writes the counter value, prescaler select and compare value, then enables counting.

Top module: `lpt_timer`

## Requirements
- R1: After reset, the status register (0x08) reads 0x2200_0000: no event flags, ready at bit 25 and clock-ready at bit 29 set. The counter (0x04), mask (0x18) and clock control (0x40) all read 0. The irq and wake outputs are low.
- R2: A write to control 0x00, counter 0x04, status-clear 0x0C, wake-enable 0x1C, compare 0x20 or periodic 0x30 sets busy (status bit 24) and clears ready (bit 25) from the next bus cycle. Busy stays set until the slow domain has taken the value. Until then, the written register still reads its previous value.
- R3: A write to any register of that group while busy is set has no effect.
- R4: Control bit 0 enables counting and control bits 20:16 (PSEL) select the prescaler. Clock bit 8 picks the source: 0 means one pulse per slow clock edge, 1 means one pulse per rising edge of alt_tick. When counting and the clock is enabled, the counter advances by one every 2^(PSEL+1) source pulses. Writing 0x04 loads the counter.
- R5: When the counter advances from 0xFFFF_FFFF it wraps to 0 and sets the wrap flag, status bit 0.
- R6: When the counter advances onto the value of the compare register 0x20, the alarm flag (status bit 8) is set.
- R7: The periodic flag (status bit 16) is set on each source pulse at which the prescaler has counted a multiple of 2^(P+1) pulses since it was last cleared, where P is bits 4:0 of register 0x30.
- R8: Writing 1 to a bit of 0x0C (0, 8 or 16) clears that flag. Other flags are kept.
- R9: Writing 1s to 0x10 sets the matching mask bits, writing 1s to 0x14 clears them, and 0x18 reads the mask back at bits 0, 8 and 16.
- R10: irq is high when any flag is set whose mask bit is set. wake is high when any flag is set whose bit in 0x1C is set.
- R11: Clock control 0x40 holds the clock enable at bit 0 and the source select at bit 8. A write sets clock-busy (bit 28) and clears clock-ready (bit 29) until it takes effect. With the clock enable at 0 the counter holds.
- R12: Writing control with bit 1 set returns the prescaler to zero. Bit 1 is a strobe and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| slow_clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| alt_tick | input | 1 | Auxiliary pulse source, sampled in the slow domain |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Masked event interrupt (bus domain) |
| wake | output | 1 | Wake request (slow domain) |

## Verification
The wrap flag and the alarm flag can be raised by the same counter step. This happens when the compare register is 0 and the counter moves from 0xFFFF_FFFF to 0. The bench preloads the counter at all-ones with compare 0, applies exactly two auxiliary pulses at a divide-by-2 setting, and expects both status bits 0 and 8 together with a counter of 0. Pulses are counted from the auxiliary input, so the expected counts do not depend on the phase between the two clocks.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT  = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] A_SCLR = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h10;
  localparam logic [ADDR_W-1:0] A_IDIS = 8'h14;
  localparam logic [ADDR_W-1:0] A_IMSK = 8'h18;
  localparam logic [ADDR_W-1:0] A_WAKE = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ALRM = 8'h20;
  localparam logic [ADDR_W-1:0] A_PER  = 8'h30;
  localparam logic [ADDR_W-1:0] A_CLK  = 8'h40;

  // status word bit positions
  localparam int B_OVF   = 0;
  localparam int B_ALM   = 8;
  localparam int B_PER   = 16;
  localparam int B_BUSY  = 24;
  localparam int B_RDY   = 25;
  localparam int B_CBUSY = 28;
  localparam int B_CRDY  = 29;

  localparam int CR_EN   = 0;
  localparam int CR_PCLR = 1;
  localparam int CR_PSEL = 16;
  localparam int CK_EN   = 0;
  localparam int CK_SEL  = 8;

  // compact event vector used internally
  localparam int E_OVF = 0;
  localparam int E_ALM = 1;
  localparam int E_PER = 2;
  typedef logic [2:0] evt_t;

  function automatic logic [DATA_W-1:0] evt_to_word(evt_t e);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[B_OVF] = e[E_OVF];
    w[B_ALM] = e[E_ALM];
    w[B_PER] = e[E_PER];
    return w;
  endfunction

  function automatic evt_t word_to_evt(logic [DATA_W-1:0] w);
    evt_t e;
    e[E_OVF] = w[B_OVF];
    e[E_ALM] = w[B_ALM];
    e[E_PER] = w[B_PER];
    return e;
  endfunction
endpackage

// File: rtl/lpt_rst_sync.sv
module lpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb chain_nx = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nx;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpt_wr_bridge.sv
// Carries one register write from the bus clock into the slow clock with a
// toggle request / toggle acknowledge pair. busy covers the full round trip.
module lpt_wr_bridge #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  input  logic          sclk,
  input  logic          srst_n,
  output logic          fire,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data
);
  logic          req_q, req_nx;
  logic [AW-1:0] hold_a_q, hold_a_nx;
  logic [DW-1:0] hold_d_q, hold_d_nx;
  logic          ack_b;
  logic          req_s, req_d_q;
  logic          accept;

  lpt_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(bclk), .rst_n(brst_n), .d(req_d_q), .q(ack_b)
  );

  assign busy   = req_q ^ ack_b;
  assign accept = wr_req & ~busy;

  always_comb begin
    req_nx    = req_q;
    hold_a_nx = hold_a_q;
    hold_d_nx = hold_d_q;
    if (accept) begin
      req_nx    = ~req_q;
      hold_a_nx = wr_addr;
      hold_d_nx = wr_data;
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q    <= 1'b0;
      hold_a_q <= '0;
      hold_d_q <= '0;
    end else begin
      req_q    <= req_nx;
      hold_a_q <= hold_a_nx;
      hold_d_q <= hold_d_nx;
    end
  end

  lpt_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(sclk), .rst_n(srst_n), .d(req_q), .q(req_s)
  );

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) req_d_q <= 1'b0;
    else         req_d_q <= req_s;
  end

  // staging registers are stable while busy, so the slow side reads them directly
  assign fire   = req_s ^ req_d_q;
  assign s_addr = hold_a_q;
  assign s_data = hold_d_q;
endmodule

// File: rtl/lpt_count_core.sv
module lpt_count_core
  import lpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 32,
  parameter int SEL_W  = 5,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              reg_fire,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              clk_fire,
  input  logic [DATA_W-1:0] clk_data,
  output logic              cr_en,
  output logic [SEL_W-1:0]  cr_psel,
  output logic [CNT_W-1:0]  cv,
  output logic [CNT_W-1:0]  cv_gray,
  output logic [CNT_W-1:0]  ar0,
  output logic [SEL_W-1:0]  pir,
  output evt_t              wer,
  output logic              ck_en,
  output logic              ck_sel,
  output evt_t              status,
  output logic              tick,
  output logic              wake
);
  logic             en_q, en_nx;
  logic [SEL_W-1:0] psel_q, psel_nx;
  logic [CNT_W-1:0] cv_q, cv_nx;
  logic [CNT_W-1:0] gray_q;
  logic [CNT_W-1:0] ar_q, ar_nx;
  logic [SEL_W-1:0] pir_q, pir_nx;
  evt_t             wer_q, wer_nx;
  logic             cke_q, cke_nx;
  logic             cks_q, cks_nx;
  logic [PSC_W-1:0] psc_q, psc_nx;
  evt_t             st_q, st_nx;
  evt_t             ev_set, ev_clr;
  logic             pclr, cv_load;
  logic             alt_s, alt_d_q, alt_rise;
  logic             src, run, per_hit;
  logic [PSC_W-1:0] div_mask, per_mask;

  function automatic logic [PSC_W-1:0] low_mask(logic [SEL_W-1:0] n);
    logic [PSC_W-1:0] m;
    for (int i = 0; i < PSC_W; i++) m[i] = (i <= int'(n));
    return m;
  endfunction

  lpt_sync #(.W(1), .STAGES(STAGES)) u_alt_sync (
    .clk(clk), .rst_n(rst_n), .d(alt_tick), .q(alt_s)
  );

  assign alt_rise = alt_s & ~alt_d_q;
  assign src      = cks_q ? alt_rise : 1'b1;
  assign run      = en_q & cke_q & src;
  assign div_mask = low_mask(psel_q);
  assign per_mask = low_mask(pir_q);
  assign tick     = run & ((psc_q & div_mask) == div_mask);
  assign per_hit  = run & ((psc_q & per_mask) == per_mask);

  always_comb begin
    ev_set        = '0;
    ev_set[E_OVF] = tick & (&cv_q);
    ev_set[E_ALM] = tick & ((cv_q + 1'b1) == ar_q);
    ev_set[E_PER] = per_hit;
  end

  always_comb begin
    en_nx   = en_q;
    psel_nx = psel_q;
    ar_nx   = ar_q;
    pir_nx  = pir_q;
    wer_nx  = wer_q;
    cke_nx  = cke_q;
    cks_nx  = cks_q;
    ev_clr  = '0;
    pclr    = 1'b0;
    cv_load = 1'b0;
    if (reg_fire) begin
      case (reg_addr)
        A_CTRL: begin
          en_nx   = reg_data[CR_EN];
          pclr    = reg_data[CR_PCLR];
          psel_nx = reg_data[CR_PSEL +: SEL_W];
        end
        A_CNT:  cv_load = 1'b1;
        A_SCLR: ev_clr  = word_to_evt(reg_data);
        A_WAKE: wer_nx  = word_to_evt(reg_data);
        A_ALRM: ar_nx   = reg_data[CNT_W-1:0];
        A_PER:  pir_nx  = reg_data[SEL_W-1:0];
        default: ;
      endcase
    end
    if (clk_fire) begin
      cke_nx = clk_data[CK_EN];
      cks_nx = clk_data[CK_SEL];
    end
    if (pclr)     psc_nx = '0;
    else if (run) psc_nx = psc_q + 1'b1;
    else          psc_nx = psc_q;
    if (cv_load)   cv_nx = reg_data[CNT_W-1:0];
    else if (tick) cv_nx = cv_q + 1'b1;
    else           cv_nx = cv_q;
    // a flag raised in the same cycle as its clear stays set
    st_nx = (st_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      psel_q  <= '0;
      cv_q    <= '0;
      gray_q  <= '0;
      ar_q    <= '0;
      pir_q   <= '0;
      wer_q   <= '0;
      cke_q   <= 1'b0;
      cks_q   <= 1'b0;
      psc_q   <= '0;
      st_q    <= '0;
      alt_d_q <= 1'b0;
    end else begin
      en_q    <= en_nx;
      psel_q  <= psel_nx;
      cv_q    <= cv_nx;
      gray_q  <= cv_nx ^ (cv_nx >> 1);
      ar_q    <= ar_nx;
      pir_q   <= pir_nx;
      wer_q   <= wer_nx;
      cke_q   <= cke_nx;
      cks_q   <= cks_nx;
      psc_q   <= psc_nx;
      st_q    <= st_nx;
      alt_d_q <= alt_s;
    end
  end

  assign cr_en   = en_q;
  assign cr_psel = psel_q;
  assign cv      = cv_q;
  assign cv_gray = gray_q;
  assign ar0     = ar_q;
  assign pir     = pir_q;
  assign wer     = wer_q;
  assign ck_en   = cke_q;
  assign ck_sel  = cks_q;
  assign status  = st_q;
  assign wake    = |(st_q & wer_q);
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 32,
  parameter int SEL_W  = 5,
  parameter int STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic              bus_rst_n, slow_rst_n;
  logic              bus_wr_en;
  logic              reg_wr_req, clk_wr_req;
  logic              reg_busy, clk_busy;
  logic              s_fire, c_fire;
  logic [ADDR_W-1:0] s_addr, c_addr;
  logic [DATA_W-1:0] s_data, c_data;
  logic              cr_en, ck_en, ck_sel, tick;
  logic [SEL_W-1:0]  cr_psel, pir;
  logic [CNT_W-1:0]  cv, cv_gray, cv_gray_b, cv_b, ar0;
  evt_t              wer, status, stat_b;
  evt_t              imr_q, imr_nx;

  function automatic logic [CNT_W-1:0] gray2bin(logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  lpt_rst_sync #(.STAGES(STAGES)) u_brst (.clk(bus_clk),  .arst_n(rst_n), .srst_n(bus_rst_n));
  lpt_rst_sync #(.STAGES(STAGES)) u_srst (.clk(slow_clk), .arst_n(rst_n), .srst_n(slow_rst_n));

  assign bus_wr_en  = bus_sel & bus_wr;
  assign reg_wr_req = bus_wr_en & ((bus_addr == A_CTRL) | (bus_addr == A_CNT)  |
                                   (bus_addr == A_SCLR) | (bus_addr == A_WAKE) |
                                   (bus_addr == A_ALRM) | (bus_addr == A_PER));
  assign clk_wr_req = bus_wr_en & (bus_addr == A_CLK);

  lpt_wr_bridge #(.AW(ADDR_W), .DW(DATA_W), .STAGES(STAGES)) u_reg_br (
    .bclk(bus_clk), .brst_n(bus_rst_n), .wr_req(reg_wr_req), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .busy(reg_busy), .sclk(slow_clk), .srst_n(slow_rst_n),
    .fire(s_fire), .s_addr(s_addr), .s_data(s_data)
  );

  lpt_wr_bridge #(.AW(ADDR_W), .DW(DATA_W), .STAGES(STAGES)) u_clk_br (
    .bclk(bus_clk), .brst_n(bus_rst_n), .wr_req(clk_wr_req), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .busy(clk_busy), .sclk(slow_clk), .srst_n(slow_rst_n),
    .fire(c_fire), .s_addr(c_addr), .s_data(c_data)
  );

  lpt_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W), .STAGES(STAGES)) u_core (
    .clk(slow_clk), .rst_n(slow_rst_n), .alt_tick(alt_tick),
    .reg_fire(s_fire), .reg_addr(s_addr), .reg_data(s_data),
    .clk_fire(c_fire & (c_addr == A_CLK)), .clk_data(c_data),
    .cr_en(cr_en), .cr_psel(cr_psel), .cv(cv), .cv_gray(cv_gray), .ar0(ar0),
    .pir(pir), .wer(wer), .ck_en(ck_en), .ck_sel(ck_sel), .status(status),
    .tick(tick), .wake(wake)
  );

  lpt_sync #(.W(CNT_W), .STAGES(STAGES)) u_cv_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(cv_gray), .q(cv_gray_b)
  );
  lpt_sync #(.W(3), .STAGES(STAGES)) u_st_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(status), .q(stat_b)
  );

  assign cv_b = gray2bin(cv_gray_b);

  always_comb begin
    imr_nx = imr_q;
    if (bus_wr_en && bus_addr == A_IEN)  imr_nx = imr_q | word_to_evt(bus_wdata);
    if (bus_wr_en && bus_addr == A_IDIS) imr_nx = imr_q & ~word_to_evt(bus_wdata);
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) imr_q <= '0;
    else            imr_q <= imr_nx;
  end

  assign irq = |(stat_b & imr_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CR_EN]              = cr_en;
        bus_rdata[CR_PSEL +: SEL_W]   = cr_psel;
      end
      A_CNT:  bus_rdata[CNT_W-1:0] = cv_b;
      A_STAT: begin
        bus_rdata          = evt_to_word(stat_b);
        bus_rdata[B_BUSY]  = reg_busy;
        bus_rdata[B_RDY]   = ~reg_busy;
        bus_rdata[B_CBUSY] = clk_busy;
        bus_rdata[B_CRDY]  = ~clk_busy;
      end
      A_IMSK: bus_rdata = evt_to_word(imr_q);
      A_WAKE: bus_rdata = evt_to_word(wer);
      A_ALRM: bus_rdata[CNT_W-1:0] = ar0;
      A_PER:  bus_rdata[SEL_W-1:0] = pir;
      A_CLK: begin
        bus_rdata[CK_EN]  = ck_en;
        bus_rdata[CK_SEL] = ck_sel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
  import lpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              bus_clk,
  input logic              slow_clk,
  input logic              bus_rst_n,
  input logic              slow_rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              reg_wr_req,
  input logic              reg_busy,
  input logic              clk_wr_req,
  input logic              clk_busy,
  input evt_t              imr,
  input logic              irq,
  input logic              s_fire,
  input logic [ADDR_W-1:0] s_addr,
  input logic              tick,
  input logic [CNT_W-1:0]  cv,
  input evt_t              status,
  input evt_t              wer,
  input logic              wake
);
  p_busy_rise_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (reg_wr_req && !reg_busy) |=> reg_busy);

  p_clk_busy_rise_r11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clk_wr_req && !clk_busy) |=> clk_busy);

  p_mask_set_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_sel && bus_wr && bus_addr == A_IEN)
      |=> ((imr & word_to_evt($past(bus_wdata))) == word_to_evt($past(bus_wdata))));

  p_mask_clear_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_sel && bus_wr && bus_addr == A_IDIS && !(bus_addr == A_IEN))
      |=> ((imr & word_to_evt($past(bus_wdata))) == '0));

  p_irq_masked_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (imr == '0) |-> !irq);

  p_cnt_step_r4: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (tick && !(s_fire && s_addr == A_CNT)) |=> (cv == $past(cv) + 1'b1));

  p_cnt_hold_r4: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (!tick && !(s_fire && s_addr == A_CNT)) |=> $stable(cv));

  p_wrap_flag_r5: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (tick && (&cv) && !(s_fire && s_addr == A_CNT)) |=> (cv == '0 && status[E_OVF]));

  p_wake_gate_r10: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (wer == '0) |-> !wake);
endmodule

bind lpt_timer lpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .bus_clk(bus_clk), .slow_clk(slow_clk), .bus_rst_n(bus_rst_n), .slow_rst_n(slow_rst_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .reg_wr_req(reg_wr_req), .reg_busy(reg_busy), .clk_wr_req(clk_wr_req), .clk_busy(clk_busy),
  .imr(imr_q), .irq(irq), .s_fire(s_fire), .s_addr(s_addr), .tick(tick), .cv(cv),
  .status(status), .wer(wer), .wake(wake)
);

// File: tb/lpt_timer_test.sv
`timescale 1ns/1ps
module lpt_timer_test;
  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 bus_clk = ~bus_clk;
  always #37 slow_clk = ~slow_clk;

  lpt_timer uut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .alt_tick(alt_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      bus_read(8'h08, s);
      if (s[24] == 1'b0 && s[28] == 1'b0) break;
    end
    repeat (4) @(negedge bus_clk);
  endtask

  task automatic wr_sync(input logic [7:0] a, input logic [31:0] d);
    bus_write(a, d);
    wait_idle();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge slow_clk) alt_tick = 1'b1;
      repeat (3) @(negedge slow_clk);
      alt_tick = 1'b0;
      repeat (3) @(negedge slow_clk);
    end
    repeat (6) @(negedge slow_clk);
    repeat (4) @(negedge bus_clk);
  endtask

  function automatic logic [31:0] expect_cv(logic [31:0] pre, int k, int psel);
    return pre + 32'(k >> (psel + 1));
  endfunction

  initial begin
    repeat (150000) @(posedge bus_clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] r, a0, a1;
    void'($urandom(32'd2024));
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge slow_clk);

    // R1 reset state
    bus_read(8'h08, r); check("R1 status", r, 32'h2200_0000);
    bus_read(8'h04, r); check("R1 counter", r, 32'h0);
    bus_read(8'h18, r); check("R1 mask", r, 32'h0);
    bus_read(8'h40, r); check("R1 clock", r, 32'h0);
    check("R1 irq/wake", {30'd0, irq, wake}, 32'h0);

    // R11 clock control handshake
    bus_write(8'h40, 32'h101);
    bus_read(8'h08, r); check("R11 clock busy", r & 32'h3000_0000, 32'h1000_0000);
    wait_idle();
    bus_read(8'h40, r); check("R11 clock readback", r, 32'h101);

    // R2 busy and old readback, R3 write during busy dropped
    bus_write(8'h20, 32'h1234);
    bus_read(8'h08, r); check("R2 busy set", r & 32'h0300_0000, 32'h0100_0000);
    bus_read(8'h20, r); check("R2 old value", r, 32'h0);
    bus_write(8'h20, 32'h5555);
    wait_idle();
    bus_read(8'h20, r); check("R3 dropped write", r, 32'h1234);
    bus_read(8'h08, r); check("R2 ready again", r & 32'h0300_0000, 32'h0200_0000);

    // R4 divide by 4 on auxiliary pulses
    wr_sync(8'h00, 32'h0001_0002);
    wr_sync(8'h04, 32'd100);
    wr_sync(8'h00, 32'h0001_0001);
    pulses(9);
    bus_read(8'h04, r); check("R4 divide by 4", r, 32'd102);
    bus_read(8'h00, r); check("R12 strobe reads 0", r, 32'h0001_0001);

    // R12 prescaler clear
    wr_sync(8'h00, 32'h0001_0003);
    pulses(3);
    bus_read(8'h04, r); check("R12 after clear", r, 32'd102);
    pulses(1);
    bus_read(8'h04, r); check("R12 first step", r, 32'd103);

    // R5 wrap with interrupt
    wr_sync(8'h00, 32'h0000_0003);
    wr_sync(8'h04, 32'hFFFF_FFFE);
    wr_sync(8'h0C, 32'h0001_0101);
    bus_write(8'h10, 32'h1);
    pulses(4);
    bus_read(8'h04, r); check("R5 wrapped", r, 32'h0);
    bus_read(8'h08, r); check("R5 flags", r & 32'h0001_0101, 32'h0001_0001);
    check("R10 irq on wrap", {31'd0, irq}, 32'h1);

    // R8 clear one flag
    wr_sync(8'h0C, 32'h1);
    bus_read(8'h08, r); check("R8 clear wrap", r & 32'h0001_0101, 32'h0001_0000);
    check("R10 irq after clear", {31'd0, irq}, 32'h0);

    // R9 mask set and clear
    bus_write(8'h10, 32'h0001_0100);
    bus_read(8'h18, r); check("R9 mask set", r, 32'h0001_0101);
    bus_write(8'h14, 32'h1);
    bus_read(8'h18, r); check("R9 mask clear", r, 32'h0001_0100);
    repeat (2) @(negedge bus_clk);
    check("R10 irq from periodic", {31'd0, irq}, 32'h1);
    bus_write(8'h14, 32'h0001_0100);
    repeat (2) @(negedge bus_clk);
    check("R10 irq masked off", {31'd0, irq}, 32'h0);

    // R6 alarm coinciding with wrap
    wr_sync(8'h00, 32'h0000_0003);
    wr_sync(8'h20, 32'h0);
    wr_sync(8'h04, 32'hFFFF_FFFF);
    wr_sync(8'h0C, 32'h0001_0101);
    pulses(2);
    bus_read(8'h08, r); check("R6 alarm with wrap", r & 32'h0000_0101, 32'h0000_0101);
    bus_read(8'h04, r); check("R5 counter after wrap", r, 32'h0);

    // R6 alarm on plain match
    wr_sync(8'h0C, 32'h0001_0101);
    wr_sync(8'h20, 32'd5);
    pulses(8);
    bus_read(8'h08, r); check("R6 no alarm yet", r & 32'h100, 32'h0);
    pulses(2);
    bus_read(8'h08, r); check("R6 alarm set", r & 32'h100, 32'h100);
    bus_read(8'h04, r); check("R6 counter at match", r, 32'd5);

    // R10 wake gating
    check("R10 wake off", {31'd0, wake}, 32'h0);
    wr_sync(8'h1C, 32'h100);
    check("R10 wake on alarm", {31'd0, wake}, 32'h1);
    wr_sync(8'h1C, 32'h1);
    check("R10 wake gated", {31'd0, wake}, 32'h0);
    wr_sync(8'h1C, 32'h0);

    // R7 periodic every 8 pulses
    wr_sync(8'h30, 32'd2);
    wr_sync(8'h00, 32'h0004_0003);
    wr_sync(8'h0C, 32'h0001_0101);
    pulses(7);
    bus_read(8'h08, r); check("R7 before period", r & 32'h0001_0000, 32'h0);
    pulses(1);
    bus_read(8'h08, r); check("R7 at period", r & 32'h0001_0000, 32'h0001_0000);

    // R4 slow-clock source runs; R11 clock enable off holds
    wr_sync(8'h00, 32'h0000_0001);
    wr_sync(8'h40, 32'h001);
    bus_read(8'h04, a0);
    repeat (40) @(negedge bus_clk);
    bus_read(8'h04, a1);
    check("R4 free running", {31'd0, a1 != a0}, 32'h1);
    wr_sync(8'h40, 32'h000);
    bus_read(8'h04, a0);
    repeat (40) @(negedge bus_clk);
    bus_read(8'h04, a1);
    check("R11 halted", a1, a0);

    // R4/R5 random trials on auxiliary pulses
    wr_sync(8'h40, 32'h101);
    wr_sync(8'h30, 32'd31);
    for (int t = 0; t < 20; t++) begin
      int ps, k;
      logic [31:0] pre, e;
      ps  = int'($urandom % 3);
      k   = int'($urandom % 24);
      pre = (t % 4 == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
      wr_sync(8'h00, (32'(ps) << 16) | 32'h2);
      wr_sync(8'h04, pre);
      wr_sync(8'h0C, 32'h0001_0101);
      wr_sync(8'h00, (32'(ps) << 16) | 32'h1);
      pulses(k);
      e = expect_cv(pre, k, ps);
      bus_read(8'h04, r); check("R4 random count", r, e);
      bus_read(8'h08, r); check("R5 random wrap flag", r & 32'h1, {31'd0, (e < pre)});
    end

    finish_up();
  end
endmodule